// File: doc/BRIEF.md
# Packed Horizontal Add-Subtract Unit

This block takes two 64-bit sources, each holding two single-precision values, and folds every source into one 32-bit result lane. The lower result lane always receives the lower value of the first source minus its upper value. The upper result lane comes from the second source: a mode input either subtracts its upper value from its lower value, or adds the two together. Both lanes use round-to-nearest-even on the exactly aligned operands.

Special values follow fixed conventions rather than IEEE rules. Operands whose exponent field is zero count as zero whatever their fraction holds. A rounded result that would need an exponent field of 255 or more is clamped to the largest finite magnitude. A nonzero result below the smallest normal magnitude is flushed to a signed zero. The sign of every zero result is chosen by rules that depend on which operand is larger. Operands with an all-ones exponent are outside the supported range, and the lane that receives one gives an undefined value. The result is registered, so it appears one clock after the operands, marked by a valid strobe.

Top module: `horiz_addsub_unit`

## Requirements
- R1: `result[31:0]` equals `srcA[31:0] - srcA[63:32]` in single precision, rounded to nearest with ties to even.
- R2: With `modeAdd` = 0, `result[63:32]` equals `srcB[31:0] - srcB[63:32]`, rounded to nearest even.
- R3: With `modeAdd` = 1, `result[63:32]` equals `srcB[31:0] + srcB[63:32]`, rounded to nearest even.
- R4: When the two operands of a lane are not both zero and the exact result is zero, the lane gives zero (exponent and fraction fields clear) with bit 31 of the lane equal to the sign of the lower operand.
- R5: When both operands of a lane are zero, the lane gives zero whose sign is the lower operand's sign ANDed with the inverted upper sign when subtracting, or ANDed with the upper sign when adding.
- R6: A nonzero result whose rounded biased exponent is 0 or less is flushed to zero; its sign is the lower operand's sign when the lower operand has the strictly larger magnitude, and otherwise the inverted upper sign when subtracting or the upper sign when adding.
- R7: A result whose rounded biased exponent is 255 or more becomes exponent field 254 with an all-ones fraction (magnitude of about 3.4e38), carrying the lower operand's sign.
- R8: An operand with exponent field 0 is treated as zero regardless of its fraction bits.
- R9: `outValid` is high in the cycle after a cycle with `inValid` high and low in the cycle after a cycle with `inValid` low; `result` is updated in that same cycle.
- R10: During and after reset `outValid` and `result` are zero, and `result` holds its value through every cycle without `inValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and mode are present this cycle |
| modeAdd | input | 1 | Upper lane operation: 0 subtract, 1 add |
| srcA | input | 64 | First source; bits 31:0 lower value, bits 63:32 upper value |
| srcB | input | 64 | Second source; same layout as the first |
| outValid | output | 1 | Result register holds a new result |
| result | output | 64 | Bits 31:0 from the first source, bits 63:32 from the second |

## Verification
The bench aims at exact cancellation and pairs of zeros in both modes, where a design that reused IEEE sign rules or reversed the operand order would show the wrong signed zero. It drives results just below the smallest normal with either operand larger, which a design without flushing would turn into a subnormal and a design with a swapped magnitude test would give the wrong sign. It pushes sums and differences past the largest finite value, where a missing clamp would produce an infinity encoding, and places exact halfway cases on both even and odd fractions, where truncation or round-half-up would be off by one unit in the last place. Zero-exponent operands carrying nonzero fractions catch a datapath that still reads their fraction.

// File: rtl/haddsub_pkg.sv
package haddsub_pkg;
  // Single-precision field widths.
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int LANE_W = 1 + EXP_W + FRAC_W;
  // Each source carries two values; one result lane per source.
  localparam int LANES  = 2;
  localparam int SRC_W  = 2 * LANE_W;
  localparam int RES_W  = LANES * LANE_W;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic load;   // capture the lane results this cycle
    logic hiAdd;  // last lane adds instead of subtracting
  } fold_ctrl_t;
endpackage

// File: rtl/haddsub_lzc.sv
module haddsub_lzc #(
  parameter int IN_W  = 27,
  parameter int CNT_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  vec,
  output logic [CNT_W-1:0] zeros
);
  logic found;

  always_comb begin
    zeros = '0;
    found = 1'b0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (vec[i]) found = 1'b1;
        else        zeros = zeros + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/haddsub_lane.sv
module haddsub_lane #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] loOp,
  input  logic [EXP_W+FRAC_W:0] hiOp,
  input  logic                  isAdd,
  output logic [EXP_W+FRAC_W:0] res
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int MAG_W = EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int GRS   = 3;
  localparam int EXT_W = SIG_W + GRS;
  localparam int SH_W  = $clog2(EXT_W + 1);
  localparam int SE_W  = EXP_W + 2;
  localparam int EMAX  = (1 << EXP_W) - 1;

  // Operand decode: zero exponent means zero magnitude.
  logic             loSign, hiEff, effSub;
  logic [EXP_W-1:0] loExp, hiExp;
  logic             loZero, hiZero, bothZero;
  logic [MAG_W-1:0] loKey, hiKey, bigKey, smallKey;
  logic             loGe, loGt, bigSign;

  assign loSign   = loOp[W-1];
  assign hiEff    = hiOp[W-1] ^ ~isAdd;
  assign effSub   = loSign ^ hiEff;
  assign loExp    = loOp[W-2:FRAC_W];
  assign hiExp    = hiOp[W-2:FRAC_W];
  assign loZero   = (loExp == '0);
  assign hiZero   = (hiExp == '0);
  assign bothZero = loZero & hiZero;
  assign loKey    = loZero ? '0 : loOp[W-2:0];
  assign hiKey    = hiZero ? '0 : hiOp[W-2:0];
  assign loGe     = (loKey >= hiKey);
  assign loGt     = (loKey > hiKey);
  assign bigKey   = loGe ? loKey : hiKey;
  assign smallKey = loGe ? hiKey : loKey;
  assign bigSign  = loGe ? loSign : hiEff;

  // Alignment of the smaller operand, tail collapsed into a sticky bit.
  logic [EXP_W-1:0]   bigExp, smallExp, expDiff;
  logic [SIG_W-1:0]   bigSig, smallSig;
  logic [SH_W-1:0]    shiftAmt;
  logic [2*EXT_W-1:0] alignWide;
  logic [EXT_W-1:0]   bigExt, smallAl, smallFin;
  logic               sticky;

  assign bigExp    = bigKey[MAG_W-1:FRAC_W];
  assign smallExp  = smallKey[MAG_W-1:FRAC_W];
  assign bigSig    = {|bigExp, bigKey[FRAC_W-1:0]};
  assign smallSig  = {|smallExp, smallKey[FRAC_W-1:0]};
  assign expDiff   = bigExp - smallExp;
  assign shiftAmt  = (expDiff >= EXP_W'(EXT_W)) ? SH_W'(EXT_W) : SH_W'(expDiff);
  assign alignWide = {smallSig, {GRS{1'b0}}, {EXT_W{1'b0}}} >> shiftAmt;
  assign smallAl   = alignWide[2*EXT_W-1:EXT_W];
  assign sticky    = |alignWide[EXT_W-1:0];
  assign smallFin  = {smallAl[EXT_W-1:1], smallAl[0] | sticky};
  assign bigExt    = {bigSig, {GRS{1'b0}}};

  // Magnitude add or subtract (big >= small, so no negative result).
  logic [EXT_W:0]   sumW;
  logic [SH_W-1:0]  lzCnt;
  logic             exactZero;

  always_comb begin
    if (effSub) sumW = {1'b0, bigExt - smallFin};
    else        sumW = {1'b0, bigExt} + {1'b0, smallFin};
  end

  assign exactZero = effSub && (sumW[EXT_W-1:0] == '0);

  haddsub_lzc #(.IN_W(EXT_W), .CNT_W(SH_W)) u_lzc (
    .vec   (sumW[EXT_W-1:0]),
    .zeros (lzCnt)
  );

  // Normalization; exponent kept in two's complement of SE_W bits.
  logic [EXT_W-1:0] normSig;
  logic [SE_W-1:0]  normExp;

  always_comb begin
    if (sumW[EXT_W]) begin
      normSig = {sumW[EXT_W:2], sumW[1] | sumW[0]};
      normExp = {2'b00, bigExp} + SE_W'(1);
    end else begin
      normSig = sumW[EXT_W-1:0] << lzCnt;
      normExp = {2'b00, bigExp} - SE_W'(lzCnt);
    end
  end

  // Round to nearest, ties to even.
  logic [SIG_W-1:0]  mantKeep;
  logic              guardBit, restBits, roundUp;
  logic [SIG_W:0]    mantR;
  logic [SE_W-1:0]   finalExp;
  logic [FRAC_W-1:0] finalFrac;
  logic              ovf, tiny;

  assign mantKeep  = normSig[EXT_W-1:GRS];
  assign guardBit  = normSig[GRS-1];
  assign restBits  = |normSig[GRS-2:0];
  assign roundUp   = guardBit & (restBits | mantKeep[0]);
  assign mantR     = {1'b0, mantKeep} + (SIG_W+1)'(roundUp);
  assign finalExp  = mantR[SIG_W] ? normExp + SE_W'(1) : normExp;
  assign finalFrac = mantR[SIG_W] ? mantR[FRAC_W:1] : mantR[FRAC_W-1:0];
  assign ovf       = !finalExp[SE_W-1] && (finalExp >= SE_W'(EMAX));
  assign tiny      = finalExp[SE_W-1] || (finalExp == '0);

  // Result selection, special cases in priority order.
  always_comb begin
    if (bothZero)
      res = {loSign & hiEff, {(W-1){1'b0}}};
    else if (exactZero)
      res = {loSign, {(W-1){1'b0}}};
    else if (ovf)
      res = {loSign, EXP_W'(EMAX - 1), {FRAC_W{1'b1}}};
    else if (tiny)
      res = {loGt ? loSign : hiEff, {(W-1){1'b0}}};
    else
      res = {bigSign, finalExp[EXP_W-1:0], finalFrac};
  end
endmodule

// File: rtl/haddsub_ctrl.sv
module haddsub_ctrl
  import haddsub_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       modeAdd,
  output fold_ctrl_t strobes,
  output logic       outValid
);
  assign strobes.load  = inValid;
  assign strobes.hiAdd = modeAdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/haddsub_datapath.sv
module haddsub_datapath
  import haddsub_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  fold_ctrl_t                   strobes,
  input  logic [LANES-1:0][SRC_W-1:0]  srcs,
  output logic [RES_W-1:0]             result
);
  logic [LANES-1:0][LANE_W-1:0] laneOut;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic laneAdd;
    if (g == LANES - 1) begin : g_sel
      assign laneAdd = strobes.hiAdd;
    end else begin : g_fix
      assign laneAdd = 1'b0;
    end

    haddsub_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
      .loOp  (srcs[g][LANE_W-1:0]),
      .hiOp  (srcs[g][SRC_W-1:LANE_W]),
      .isAdd (laneAdd),
      .res   (laneOut[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             result <= '0;
    else if (strobes.load) result <= laneOut;
  end
endmodule

// File: rtl/horiz_addsub_unit.sv
module horiz_addsub_unit
  import haddsub_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             modeAdd,
  input  logic [SRC_W-1:0] srcA,
  input  logic [SRC_W-1:0] srcB,
  output logic             outValid,
  output logic [RES_W-1:0] result
);
  fold_ctrl_t                  strobes;
  logic [LANES-1:0][SRC_W-1:0] srcs;

  assign srcs = {srcB, srcA};

  haddsub_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .modeAdd  (modeAdd),
    .strobes  (strobes),
    .outValid (outValid)
  );

  haddsub_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .srcs    (srcs),
    .result  (result)
  );
endmodule

// File: rtl/horiz_addsub_unit_chk.sv
module horiz_addsub_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        modeAdd,
  input logic [63:0] srcA,
  input logic [63:0] srcB,
  input logic        outValid,
  input logic [63:0] result
);
  logic aOk, bOk;
  assign aOk = (srcA[30:23] != 8'hFF) && (srcA[62:55] != 8'hFF);
  assign bOk = (srcB[30:23] != 8'hFF) && (srcB[62:55] != 8'hFF);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R9
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
  // R7
  no_top_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && aOk && bOk) |=> (result[30:23] != 8'hFF) && (result[62:55] != 8'hFF));
  // R6
  no_subnormal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && aOk) |=> (result[30:23] != 8'h00) || (result[22:0] == 23'h0));
  // R5
  zero_pair_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && srcA[30:23] == 8'h00 && srcA[62:55] == 8'h00)
      |=> result[31:0] == {$past(srcA[31]) & ~$past(srcA[63]), 31'h0});
  // R5
  zero_pair_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeAdd && srcB[30:23] == 8'h00 && srcB[62:55] == 8'h00)
      |=> result[63:32] == {$past(srcB[31]) & $past(srcB[63]), 31'h0});
  // R4
  cancel_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && aOk && srcA[30:23] != 8'h00 && srcA[30:0] == srcA[62:32] && srcA[31] == srcA[63])
      |=> result[31:0] == {$past(srcA[31]), 31'h0});
endmodule

bind horiz_addsub_unit horiz_addsub_unit_chk u_chk (.*);

// File: tb/horiz_addsub_unit_bench.sv
module horiz_addsub_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        modeAdd = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        outValid;
  logic [63:0] result;

  int    checks = 0;
  int    failures = 0;
  bit    started = 1'b0;
  bit    finished = 1'b0;
  string curTag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  horiz_addsub_unit u_horiz_addsub_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeAdd(modeAdd),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result)
  );

  // Behavioural lane model: exact integer sum, then rounding and the special rules.
  function automatic logic [31:0] refLane(input logic [31:0] lo, input logic [31:0] hi, input bit isAdd);
    bit sa, sb, neg;
    int ea, eb, emin, p, e, sh;
    longint ia, ib, tot, mag, keep, rem, half;
    logic [30:0] ka, kb;
    sa = lo[31];
    sb = isAdd ? hi[31] : ~hi[31];
    ea = int'(lo[30:23]);
    eb = int'(hi[30:23]);
    if (ea == 0 && eb == 0) return {sa & sb, 31'h0};
    ka = (ea == 0) ? 31'h0 : lo[30:0];
    kb = (eb == 0) ? 31'h0 : hi[30:0];
    if (ea == 0) emin = eb;
    else if (eb == 0) emin = ea;
    else emin = (ea < eb) ? ea : eb;
    ia = (ea == 0) ? 0 : (longint'({1'b1, lo[22:0]}) <<< (ea - emin));
    ib = (eb == 0) ? 0 : (longint'({1'b1, hi[22:0]}) <<< (eb - emin));
    tot = (sa ? -ia : ia) + (sb ? -ib : ib);
    if (tot == 0) return {sa, 31'h0};
    neg = (tot < 0);
    mag = neg ? -tot : tot;
    p = 0;
    for (int i = 0; i < 63; i++) if (mag[i]) p = i;
    e = p + emin - 23;
    if (p > 23) begin
      sh = p - 23;
      keep = mag >>> sh;
      rem = mag & ((longint'(1) <<< sh) - 1);
      half = longint'(1) <<< (sh - 1);
      if (rem > half || (rem == half && keep[0])) keep = keep + 1;
      if (keep == (longint'(1) <<< 24)) begin
        keep = keep >>> 1;
        e = e + 1;
      end
    end else begin
      keep = mag <<< (23 - p);
    end
    if (e >= 255) return {sa, 8'hFE, 23'h7FFFFF};
    if (e <= 0) return {(ka > kb) ? sa : sb, 31'h0};
    return {neg, e[7:0], keep[22:0]};
  endfunction

  function automatic bit supported(input logic [63:0] s);
    return (s[30:23] != 8'hFF) && (s[62:55] != 8'hFF);
  endfunction

  // Cycle model of the registered outputs.
  logic        expValid = 1'b0;
  logic [63:0] expRes = '0;
  bit          expLoOk = 1'b1, expHiOk = 1'b1;
  string       expTag = "R10";

  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expRes   <= '0;
      expLoOk  <= 1'b1;
      expHiOk  <= 1'b1;
      expTag   <= "R10";
    end else begin
      expValid <= inValid;
      if (inValid) begin
        expRes  <= {refLane(srcB[31:0], srcB[63:32], modeAdd), refLane(srcA[31:0], srcA[63:32], 1'b0)};
        expLoOk <= supported(srcA);
        expHiOk <= supported(srcB);
        expTag  <= curTag;
      end
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (outValid !== expValid) begin
        failures++;
        $display("FAIL R9 outValid got %b expected %b", outValid, expValid);
      end
      if (expLoOk) begin
        checks++;
        if (result[31:0] !== expRes[31:0]) begin
          failures++;
          $display("FAIL %s (R1 lane) low got %h expected %h", expValid ? expTag : "R10",
                   result[31:0], expRes[31:0]);
        end
      end
      if (expHiOk) begin
        checks++;
        if (result[63:32] !== expRes[63:32]) begin
          failures++;
          $display("FAIL %s (R2/R3 lane) high got %h expected %h", expValid ? expTag : "R10",
                   result[63:32], expRes[63:32]);
        end
      end
    end
  end

  task automatic drive(input logic [31:0] hi, input logic [31:0] lo, input bit m, input string tag);
    @(negedge clk);
    srcA    = {hi, lo};
    srcB    = {hi, lo};
    modeAdd = m;
    inValid = 1'b1;
    curTag  = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      srcA    = {$urandom, $urandom};
      srcB    = {$urandom, $urandom};
      modeAdd = $urandom % 2;
      curTag  = "R10";
    end
  endtask

  function automatic logic [31:0] rndVal(input int e);
    logic [31:0] r;
    r = $urandom;
    return {r[31], 8'(e), r[22:0]};
  endfunction

  initial begin
    @(posedge clk);
    started = 1'b1;
    repeat (3) @(negedge clk);       // R10 reset state compared each cycle
    rstN = 1'b1;
    idle(2);

    // R1 R2 basic differences
    drive(32'h3F000000, 32'h3F800000, 1'b0, "R1");
    drive(32'h40400000, 32'hC0A00000, 1'b0, "R2");
    // R3 sums
    drive(32'h3F000000, 32'h3F800000, 1'b1, "R3");
    drive(32'hC1200000, 32'h40E00000, 1'b1, "R3");
    // R4 exact cancellation
    drive(32'hC0400000, 32'hC0400000, 1'b0, "R4");
    drive(32'hC0000000, 32'h40000000, 1'b1, "R4");
    drive(32'h3F800000, 32'hBF800000, 1'b1, "R4");
    // R5 pairs of zeros
    drive(32'h00000000, 32'h00000000, 1'b0, "R5");
    drive(32'h00000000, 32'h80000000, 1'b0, "R5");
    drive(32'h80000000, 32'h80000000, 1'b1, "R5");
    drive(32'h00000000, 32'h80000000, 1'b1, "R5");
    // R6 results below the smallest normal
    drive(32'h00800000, 32'h00C00000, 1'b0, "R6");
    drive(32'h00C00000, 32'h00800000, 1'b0, "R6");
    drive(32'h00800000, 32'h80C00000, 1'b1, "R6");
    drive(32'h80C00000, 32'h00800000, 1'b1, "R6");
    // R7 overflow clamp
    drive(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b0, "R7");
    drive(32'h7F000000, 32'hFF000000, 1'b0, "R7");
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b1, "R7");
    // R8 zero-exponent operands with nonzero fraction
    drive(32'h3F800000, 32'h00000001, 1'b0, "R8");
    drive(32'h007FFFFF, 32'h40000000, 1'b1, "R8");
    // R1 rounding ties: even stays, odd rounds up
    drive(32'hB3800000, 32'h3F800000, 1'b0, "R1");
    drive(32'hB3800000, 32'h3F800001, 1'b0, "R1");
    // R10 hold while idle
    idle(3);

    for (int n = 0; n < 600; n++) begin
      int e1, e2, e3, e4;
      e1 = 1 + int'($urandom % 254);
      e2 = e1 + int'($urandom % 61) - 30;
      if (e2 < 1) e2 = 1;
      if (e2 > 254) e2 = 254;
      if ($urandom % 12 == 0) e2 = 0;
      e3 = 1 + int'($urandom % 254);
      e4 = e3 + int'($urandom % 5) - 2;
      if (e4 < 1) e4 = 1;
      if (e4 > 254) e4 = 254;
      @(negedge clk);
      srcA    = {rndVal(e2), rndVal(e1)};
      srcB    = ($urandom % 3 == 0) ? {rndVal(e3), rndVal(e3)} : {rndVal(e4), rndVal(e3)};
      modeAdd = $urandom % 2;
      inValid = ($urandom % 5 != 0);
      curTag  = modeAdd ? "R3" : "R2";
    end
    idle(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired before completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule